// File: doc/BRIEF.md
# Programmable Address Decode Window Unit

This unit sits between a CPU master and a set of downstream targets and decides, for each transaction address, which target is addressed and at which translated address. It has five windows. Each window holds an enable, a target code, a base, a size and a remap value, all in 64 KB granularity. A window's size is a run of ones starting at bit 0. The unit uses this run as a mask: the masked high address bits must equal the base, and the same mask selects which bits come from the remap value.

Software programs the windows through a simple register bus with separate write and read strobes. To move a window safely, software clears its enable, writes base, remap and size, and then writes the target code together with the enable. Decoding is combinational from the request address to the outputs. It always uses the register contents present at that moment, so each register write affects decoding from the next clock edge on.

Top module: `addr_window_decoder`

## Requirements
- R1: Window w (0 to 4) owns four 32-bit registers at byte offset 16*w: control at +0x0 (bit 0 enable, bits 7:4 target code), base at +0x4 (bits 15:0), size at +0x8 (bits 15:0) and remap at +0xC (bits 15:0). A read strobe returns the stored value on rd_data one clock later, and unimplemented bits read as zero.
- R2: A synchronous active-high reset clears every register and the read data, so no window hits after reset.
- R3: An enabled window matches when (req_addr[31:16] & ~size) equals (base & ~size). The low 16 address bits never take part in the match.
- R4: A window whose enable bit is clear never hits, whatever its other fields hold.
- R5: A size field of N consecutive ones from bit 0 gives a window of 2^N × 64 KB, that is (size+1) × 64 KB. For example, 0x00FF covers 16 MB, and the first address past the window misses.
- R6: When several enabled windows match, the lowest-numbered window supplies the target and the translation.
- R7: On a hit, out_addr[31:16] is (remap & ~size) | (req_addr[31:16] & size), and out_addr[15:0] equals req_addr[15:0].
- R8: When no window matches, miss is 1, hit is 0, hit_target is 0 and out_addr equals req_addr. hit and miss are never equal.
- R9: A register write changes the decode result only after the clock edge that captures it. Until that edge, the decode reflects the old contents.
- R10: Register accesses whose window index (reg_addr[7:4]) is 5 or more have no effect, and reads of those addresses return zero.
- R11: hit_target carries the matching window's 4-bit target code unchanged, including sparse codes such as 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data, valid one clock after rd_en |
| req_addr | input | 32 | Transaction address to decode |
| hit | output | 1 | Some enabled window matches |
| miss | output | 1 | No enabled window matches |
| hit_target | output | 4 | Target code of the winning window, 0 on miss |
| out_addr | output | 32 | Translated address, or req_addr on miss |

## Verification
If a window register is corrupted, the fault shows at the ports in the same cycle as any address that falls inside the affected window: the hit flag, the target or the upper translated bits are wrong. It also shows one clock after a read strobe, when the register is read back. A broken priority chain or a broken mask shows only for addresses in overlapping regions or at the edges of a window. The stimulus therefore targets the first and last 64 KB of each window and an area where two windows overlap. A write that takes effect too early is visible at the decode outputs before the capturing edge.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int ADDR_W  = 32;
  localparam int GRAN_W  = 16;
  localparam int FIELD_W = ADDR_W - GRAN_W;
  localparam int TGT_W   = 4;
  localparam int DATA_W  = 32;

  typedef struct packed {
    logic               en;
    logic [TGT_W-1:0]   tgt;
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] mask;
    logic [FIELD_W-1:0] remap;
  } win_cfg_t;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_REMAP = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/win_regfile.sv
module win_regfile
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int REG_AW  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [REG_AW-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output win_cfg_t [NUM_WIN-1:0]     cfg
);
  localparam int IDX_W = REG_AW - 4;

  logic [IDX_W-1:0] idx;
  reg_sel_e         sel;
  logic             idx_ok;
  logic [DATA_W-1:0] rd_mux;

  assign idx    = reg_addr[REG_AW-1:4];
  assign sel    = reg_sel_e'(reg_addr[3:2]);
  assign idx_ok = (int'(idx) < NUM_WIN);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic wsel;
    assign wsel = wr_en && idx_ok && (int'(idx) == w);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[w] <= '0;
      end else if (wsel) begin
        case (sel)
          SEL_CTRL: begin
            cfg[w].en  <= wr_data[0];
            cfg[w].tgt <= wr_data[7:4];
          end
          SEL_BASE:  cfg[w].base  <= wr_data[FIELD_W-1:0];
          SEL_MASK:  cfg[w].mask  <= wr_data[FIELD_W-1:0];
          SEL_REMAP: cfg[w].remap <= wr_data[FIELD_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (idx_ok && int'(idx) == w) begin
        case (sel)
          SEL_CTRL:  rd_mux = {{(DATA_W-8){1'b0}}, cfg[w].tgt, 3'b000, cfg[w].en};
          SEL_BASE:  rd_mux = {{(DATA_W-FIELD_W){1'b0}}, cfg[w].base};
          SEL_MASK:  rd_mux = {{(DATA_W-FIELD_W){1'b0}}, cfg[w].mask};
          SEL_REMAP: rd_mux = {{(DATA_W-FIELD_W){1'b0}}, cfg[w].remap};
          default:   rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/win_match.sv
module win_match
  import addr_win_pkg::*;
(
  input  win_cfg_t           cfg,
  input  logic [FIELD_W-1:0] addr_hi,
  output logic               hit,
  output logic [FIELD_W-1:0] xlat_hi
);
  logic [FIELD_W-1:0] keep;
  assign keep    = ~cfg.mask;
  assign hit     = cfg.en && ((addr_hi & keep) == (cfg.base & keep));
  assign xlat_hi = (cfg.remap & keep) | (addr_hi & cfg.mask);
endmodule

// File: rtl/win_prio.sv
module win_prio
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic [NUM_WIN-1:0]              hit_vec,
  input  logic [NUM_WIN-1:0][TGT_W-1:0]   tgt_vec,
  input  logic [NUM_WIN-1:0][FIELD_W-1:0] xlat_vec,
  output logic                            any_hit,
  output logic [TGT_W-1:0]                sel_tgt,
  output logic [FIELD_W-1:0]              sel_hi
);
  always_comb begin
    any_hit = 1'b0;
    sel_tgt = '0;
    sel_hi  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        sel_tgt = tgt_vec[i];
        sel_hi  = xlat_vec[i];
      end
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int REG_AW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [31:0]       req_addr,
  output logic              hit,
  output logic              miss,
  output logic [3:0]        hit_target,
  output logic [31:0]       out_addr
);
  win_cfg_t [NUM_WIN-1:0]           cfg;
  logic [NUM_WIN-1:0]               hit_vec;
  logic [NUM_WIN-1:0][TGT_W-1:0]    tgt_vec;
  logic [NUM_WIN-1:0][FIELD_W-1:0]  xlat_vec;
  logic                             any_hit;
  logic [TGT_W-1:0]                 sel_tgt;
  logic [FIELD_W-1:0]               sel_hi;

  win_regfile #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .cfg(cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    win_match match_i (
      .cfg(cfg[w]), .addr_hi(req_addr[ADDR_W-1:GRAN_W]),
      .hit(hit_vec[w]), .xlat_hi(xlat_vec[w])
    );
    assign tgt_vec[w] = cfg[w].tgt;
  end

  win_prio #(.NUM_WIN(NUM_WIN)) prio_i (
    .hit_vec(hit_vec), .tgt_vec(tgt_vec), .xlat_vec(xlat_vec),
    .any_hit(any_hit), .sel_tgt(sel_tgt), .sel_hi(sel_hi)
  );

  assign hit        = any_hit;
  assign miss       = ~any_hit;
  assign hit_target = sel_tgt;
  assign out_addr   = any_hit ? {sel_hi, req_addr[GRAN_W-1:0]} : req_addr;
endmodule

// File: rtl/addr_window_checker.sv
module addr_window_checker #(
  parameter int NUM_WIN = 5,
  parameter int REG_AW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       rd_data,
  input logic [31:0]       req_addr,
  input logic              hit,
  input logic              miss,
  input logic [3:0]        hit_target,
  input logic [31:0]       out_addr
);
  a_r8_hit_miss_excl: assert property (@(posedge clk) disable iff (rst)
    hit != miss);

  a_r8_miss_outputs: assert property (@(posedge clk) disable iff (rst)
    miss |-> (hit_target == 4'd0 && out_addr == req_addr));

  a_r7_offset_kept: assert property (@(posedge clk) disable iff (rst)
    hit |-> (out_addr[15:0] == req_addr[15:0]));

  a_r2_no_hit_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit);

  a_r1_unimpl_bits_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en) |-> (rd_data[31:16] == 16'h0));

  a_r10_out_of_range_read_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && (int'($past(reg_addr[REG_AW-1:4])) >= NUM_WIN)) |-> (rd_data == 32'h0));
endmodule

bind addr_window_decoder addr_window_checker #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .reg_addr(reg_addr), .rd_data(rd_data),
  .req_addr(req_addr), .hit(hit), .miss(miss), .hit_target(hit_target), .out_addr(out_addr)
);

// File: tb/addr_window_decoder_tb_top.sv
module addr_window_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] req_addr = '0;
  logic        hit, miss;
  logic [3:0]  hit_target;
  logic [31:0] out_addr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  addr_window_decoder dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .req_addr(req_addr), .hit(hit),
    .miss(miss), .hit_target(hit_target), .out_addr(out_addr)
  );

  // entry: {req_addr, exp_hit, exp_target, exp_out}
  localparam int NV = 11;
  localparam logic [68:0] VEC [NV] = '{
    {32'h0000_1234, 1'b1, 4'd0, 32'h0000_1234},  // R3 window 0
    {32'h7FFF_FFFC, 1'b1, 4'd0, 32'h7FFF_FFFC},  // R5 last word of 2 GB
    {32'h8000_0000, 1'b0, 4'd0, 32'h8000_0000},  // R8 gap miss
    {32'hE000_0010, 1'b1, 4'd5, 32'h1000_0010},  // R6 window 1 beats window 4
    {32'hE7FF_FFFF, 1'b1, 4'd5, 32'h17FF_FFFF},  // R7 remap keeps offset
    {32'hE800_0000, 1'b1, 4'd2, 32'hE800_0000},
    {32'hEFFF_0004, 1'b1, 4'd2, 32'hEFFF_0004},
    {32'hF000_0000, 1'b1, 4'd7, 32'h2000_0000},  // R11 code 7
    {32'hF001_ABCD, 1'b1, 4'd7, 32'h2001_ABCD},  // R5 128 KB window
    {32'hF002_0000, 1'b0, 4'd0, 32'hF002_0000},  // R5 first past end
    {32'hFFFF_0000, 1'b0, 4'd0, 32'hFFFF_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_dec(input string req, input logic [31:0] a, input logic eh,
                         input logic [3:0] et, input logic [31:0] eo);
    req_addr = a;
    #1;
    chk(req, {26'h0, hit, miss, hit_target, out_addr}, {26'h0, eh, ~eh, et, eo});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk);
    rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {32'h0, rd_data}, {32'h0, e});
  endtask

  task automatic prog(input int w, input logic [3:0] t, input logic [15:0] b,
                      input logic [15:0] s, input logic [15:0] r);
    wr(8'(w*16),     32'h0);
    wr(8'(w*16 + 4), {16'h0, b});
    wr(8'(w*16 + 12), {16'h0, r});
    wr(8'(w*16 + 8), {16'h0, s});
    wr(8'(w*16),     {24'h0, t, 4'h1});
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    rd_chk("R2 ctrl0 after reset", 8'h00, 32'h0);
    rd_chk("R2 size3 after reset", 8'h38, 32'h0);
    chk_dec("R2 no hit after reset", 32'h0000_0000, 1'b0, 4'd0, 32'h0000_0000);

    prog(0, 4'd0, 16'h0000, 16'h7FFF, 16'h0000);
    prog(1, 4'd5, 16'hE000, 16'h07FF, 16'h1000);
    prog(2, 4'd2, 16'hE800, 16'h07FF, 16'hE800);
    prog(3, 4'd7, 16'hF000, 16'h0001, 16'h2000);
    prog(4, 4'd8, 16'hE000, 16'h00FF, 16'h3300);

    for (int i = 0; i < NV; i++)
      chk_dec("R3/R5/R6/R7/R8/R11 vector", VEC[i][68:37], VEC[i][36], VEC[i][35:32], VEC[i][31:0]);

    // R1 readback, unimplemented bits zero
    rd_chk("R1 ctrl3", 8'h30, 32'h0000_0071);
    rd_chk("R1 base1", 8'h14, 32'h0000_E000);
    rd_chk("R1 remap4", 8'h4C, 32'h0000_3300);
    wr(8'h24, 32'hFFFF_E800);
    rd_chk("R1 upper bits dropped", 8'h24, 32'h0000_E800);

    // R10 out-of-range index
    wr(8'h50, 32'h0000_0081);
    wr(8'hF4, 32'h0000_0000);
    rd_chk("R10 read idx5", 8'h50, 32'h0);
    rd_chk("R10 read idx15", 8'hF4, 32'h0);
    chk_dec("R10 windows untouched", 32'hE800_0000, 1'b1, 4'd2, 32'hE800_0000);

    // R9 write takes effect at the capturing edge; R4 disabled window never hits
    @(negedge clk);
    wr_en = 1'b1; reg_addr = 8'h10; wr_data = 32'h0000_0050;
    chk_dec("R9 old contents before edge", 32'hE000_0010, 1'b1, 4'd5, 32'h1000_0010);
    @(negedge clk);
    wr_en = 1'b0;
    chk_dec("R9 R4 window1 off, window4 wins", 32'hE000_0010, 1'b1, 4'd8, 32'h3300_0010);
    chk_dec("R5 16 MB window last 64 KB", 32'hE0FF_0000, 1'b1, 4'd8, 32'h33FF_0000);
    chk_dec("R4 R5 past 16 MB misses", 32'hE100_0000, 1'b0, 4'd0, 32'hE100_0000);
    rd_chk("R4 ctrl1 target kept", 8'h10, 32'h0000_0050);

    // R2 reset again clears decoding
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_dec("R2 miss after second reset", 32'hE800_0000, 1'b0, 4'd0, 32'hE800_0000);
    rd_chk("R2 base2 cleared", 8'h24, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule